// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block times retransmissions for the transmitter of a half-duplex Ethernet port. Each reported collision increments a per-frame attempt count. The block then takes a pseudo-random slot count from a free-running 16-bit LFSR and masks it to the range that the selected backoff mode allows. It waits that many slots before it signals that the transmitter may retry. One slot is `SLOT_BITS` bit times, 512 by default, and one bit time is marked by a pulse on `bit_tick`.

Four backoff modes are selectable:
- **Standard:** truncated binary exponential backoff.
- **Capped:** the standard window for the first two collisions, then at most three slots.
- **Buffer-aware:** zero delay while the port buffer is full, otherwise standard.
- **Immediate:** zero delay always.

When `no_drop` is low, the 16th consecutive collision drops the frame. When `no_drop` is high, the frame keeps retrying. The attempt count is cleared when a frame completes, when a new frame starts, or when a frame is dropped.

Top module: `bo_ctrl`

## Requirements
- R1: After synchronous reset, `bo_done`, `frame_drop` and `bo_active` are all low.
- R2: A backoff of S slots ends after exactly S×SLOT_BITS `bit_tick` pulses. The pulses are counted from the edge after the collision edge. `bo_done` is then high for one cycle, and no progress is made while `bit_tick` is low.
- R3: In mode 2'b00 (standard), the n-th collision of a frame waits between 0 and 2^min(n,10)−1 slots.
- R4: In mode 2'b01 (capped), collisions 1 and 2 follow the standard window, and every later collision waits between 0 and 3 slots.
- R5: In mode 2'b10 (buffer-aware), a collision taken while `buf_full` is high waits zero slots. Otherwise the standard window of R3 applies.
- R6: In mode 2'b11 (immediate), every collision that does not drop the frame raises `bo_done` in the cycle after the collision.
- R7: With `no_drop` low, the 16th consecutive collision raises `frame_drop` for one cycle in the cycle after the collision, with no `bo_done`. It also clears the attempt count.
- R8: With `no_drop` high, collisions beyond the 16th never drop the frame, and they keep the window limited to 2^10−1 slots.
- R9: A `frame_done` or `tx_start` pulse clears the attempt count, so the next collision counts as the first.
- R10: `bo_active` is high from the cycle after a collision that draws a nonzero slot count until `bo_done`. It falls only together with `bo_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per bit time |
| collision | input | 1 | One-cycle pulse when the current attempt collides |
| tx_start | input | 1 | One-cycle pulse at the start of a new frame |
| frame_done | input | 1 | One-cycle pulse when a frame is sent successfully |
| buf_full | input | 1 | Port buffer full indication, sampled at the collision |
| mode | input | 2 | Backoff mode: 00 standard, 01 capped, 10 buffer-aware, 11 immediate |
| no_drop | input | 1 | 1 disables the 16-collision drop |
| bo_done | output | 1 | One-cycle pulse when the backoff wait expires |
| frame_drop | output | 1 | One-cycle pulse when the frame is dropped |
| bo_active | output | 1 | High while a backoff wait is in progress |

## Verification
The assertions assume the following about the inputs:
- A collision is reported only when no backoff is in progress.
- A collision never coincides with `frame_done` or `tx_start`.
- A new collision follows `bo_done` only after at least one idle cycle.

The stimulus keeps within these rules. Each collision pulse is issued only after the previous outcome (`bo_done` or `frame_drop`) has been observed. The frame-boundary pulses are driven on separate cycles from collisions. Since the slot draw is pseudo-random, the bench checks each wait against the window allowed for that attempt number and checks that it is an exact multiple of the slot length. It does not predict the exact draw.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic [1:0] {
        BO_STD       = 2'b00,
        BO_CAPPED    = 2'b01,
        BO_BUFAWARE  = 2'b10,
        BO_IMMEDIATE = 2'b11
    } bo_mode_e;

    localparam int            LFSR_W    = 16;
    localparam logic [15:0]   LFSR_SEED = 16'hACE1;
    localparam logic [15:0]   LFSR_TAPS = 16'hB400;
    localparam int            CAP_EXP   = 2;

    typedef struct packed {
        logic        drop;
        logic [15:0] slots;
    } bo_decision_t;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? LFSR_TAPS : 16'h0000);
    endfunction

    function automatic int unsigned window_exp(input bo_mode_e m, input logic full,
                                               input int unsigned n, input int unsigned limit);
        int unsigned std_e;
        std_e = (n > limit) ? limit : n;
        case (m)
            BO_STD:      return std_e;
            BO_CAPPED:   return (n <= CAP_EXP) ? n : CAP_EXP;
            BO_BUFAWARE: return full ? 0 : std_e;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr
    import bo_pkg::*;
#(
    parameter logic [15:0] SEED = LFSR_SEED
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= lfsr_step(state);
    end
endmodule

// File: rtl/bo_attempt.sv
module bo_attempt
    import bo_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 16,
    parameter int EXP_LIMIT    = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         collision,
    input  logic         tx_start,
    input  logic         frame_done,
    input  logic         buf_full,
    input  logic         no_drop,
    input  bo_mode_e     mode,
    input  logic [15:0]  rnd,
    output bo_decision_t dec
);
    localparam int CW = $clog2(MAX_ATTEMPTS + 1);

    logic [CW-1:0]        cnt_q;
    logic [CW-1:0]        cnt_next;
    logic [EXP_LIMIT:0]   pow2;
    logic [EXP_LIMIT-1:0] mask;
    int unsigned          e;

    always_comb begin
        cnt_next = (cnt_q == CW'(MAX_ATTEMPTS)) ? cnt_q : cnt_q + 1'b1;
        e        = window_exp(mode, buf_full, int'(cnt_next), EXP_LIMIT);
        pow2     = (EXP_LIMIT + 1)'(1) << e;
        mask     = EXP_LIMIT'(pow2 - 1'b1);
        dec.drop = (cnt_next == CW'(MAX_ATTEMPTS)) && !no_drop;
        dec.slots = 16'(rnd[EXP_LIMIT-1:0] & mask);
    end

    always_ff @(posedge clk) begin
        if (rst || tx_start || frame_done) cnt_q <= '0;
        else if (collision)                cnt_q <= dec.drop ? '0 : cnt_next;
    end
endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SLOT_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_slots,
    input  logic              tick,
    output logic              active,
    output logic              done
);
    localparam int TW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(SLOT_BITS - 1);

    logic [TW-1:0]     tcnt;
    logic [SLOT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            tcnt   <= '0;
            left   <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                tcnt <= '0;
                left <= load_slots;
                if (load_slots == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    active <= 1'b1;
                end
            end else if (active && tick) begin
                if (tcnt == T_LAST) begin
                    tcnt <= '0;
                    left <= left - 1'b1;
                    if (left == SLOT_W'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bo_ctrl.sv
module bo_ctrl
    import bo_pkg::*;
#(
    parameter int SLOT_BITS    = 512,
    parameter int MAX_ATTEMPTS = 16,
    parameter int EXP_LIMIT    = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       collision,
    input  logic       tx_start,
    input  logic       frame_done,
    input  logic       buf_full,
    input  logic [1:0] mode,
    input  logic       no_drop,
    output logic       bo_done,
    output logic       frame_drop,
    output logic       bo_active
);
    logic [15:0]  rnd;
    bo_decision_t dec;
    logic         drop_q;

    bo_lfsr u_lfsr (.clk(clk), .rst(rst), .state(rnd));

    bo_attempt #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .EXP_LIMIT(EXP_LIMIT)) u_attempt (
        .clk(clk), .rst(rst), .collision(collision), .tx_start(tx_start),
        .frame_done(frame_done), .buf_full(buf_full), .no_drop(no_drop),
        .mode(bo_mode_e'(mode)), .rnd(rnd), .dec(dec)
    );

    bo_slot_timer #(.SLOT_BITS(SLOT_BITS), .SLOT_W(EXP_LIMIT)) u_timer (
        .clk(clk), .rst(rst), .load(collision && !dec.drop),
        .load_slots(dec.slots[EXP_LIMIT-1:0]), .tick(bit_tick),
        .active(bo_active), .done(bo_done)
    );

    always_ff @(posedge clk) begin
        if (rst) drop_q <= 1'b0;
        else     drop_q <= collision && dec.drop;
    end
    assign frame_drop = drop_q;
endmodule

// File: rtl/bo_ctrl_chk.sv
module bo_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       collision,
    input logic [1:0] mode,
    input logic       no_drop,
    input logic       bo_done,
    input logic       frame_drop,
    input logic       bo_active
);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        bo_done && !collision |=> !bo_done);

    p_stall_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        bo_active && !bit_tick && !collision |=> !bo_done);

    p_immediate_r6: assert property (@(posedge clk) disable iff (rst)
        collision && mode == 2'b11 |=> bo_done || frame_drop);

    p_drop_excl_r7: assert property (@(posedge clk) disable iff (rst)
        frame_drop |-> !bo_done && !bo_active);

    p_drop_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        frame_drop |-> $past(!no_drop));

    p_active_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(bo_active) |-> bo_done);
endmodule

bind bo_ctrl bo_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .collision(collision),
    .mode(mode), .no_drop(no_drop), .bo_done(bo_done),
    .frame_drop(frame_drop), .bo_active(bo_active)
);

// File: tb/bo_ctrl_bench.sv
module bo_ctrl_bench;
    localparam int SB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b1, collision = 1'b0, tx_start = 1'b0, frame_done = 1'b0;
    logic buf_full = 1'b0, no_drop = 1'b0;
    logic [1:0] mode = 2'b00;
    logic bo_done, frame_drop, bo_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    bo_ctrl #(.SLOT_BITS(SB)) u_bo_ctrl (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .collision(collision),
        .tx_start(tx_start), .frame_done(frame_done), .buf_full(buf_full),
        .mode(mode), .no_drop(no_drop), .bo_done(bo_done),
        .frame_drop(frame_drop), .bo_active(bo_active)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [1:0] md;
        logic       full;
        logic       nd;
        logic [5:0] ncoll;
        logic       expdrop;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 1'b0, 6'd6,  1'b0},
        '{2'b00, 1'b0, 1'b0, 6'd16, 1'b1},
        '{2'b01, 1'b0, 1'b0, 6'd8,  1'b0},
        '{2'b10, 1'b1, 1'b0, 6'd5,  1'b0},
        '{2'b10, 1'b0, 1'b0, 6'd5,  1'b0},
        '{2'b11, 1'b0, 1'b0, 6'd16, 1'b1},
        '{2'b11, 1'b0, 1'b1, 6'd20, 1'b0},
        '{2'b01, 1'b0, 1'b1, 6'd18, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_max(input int md, input bit full, input int n);
        int e;
        case (md)
            0: e = (n > 10) ? 10 : n;
            1: e = (n <= 2) ? n : 2;
            2: e = full ? 0 : ((n > 10) ? 10 : n);
            default: e = 0;
        endcase
        return (1 << e) - 1;
    endfunction

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Collide, then count posedges until done or drop is seen.
    task automatic collide(output int cycles, output bit dropped, output bit act_ok);
        @(negedge clk); collision = 1'b1;
        @(negedge clk); collision = 1'b0;
        cycles = 1; act_ok = 1'b1;
        while (!bo_done && !frame_drop && cycles < 6000) begin
            if (!bo_active) act_ok = 1'b0;
            @(negedge clk); cycles++;
        end
        dropped = frame_drop;
        if (bo_done && frame_drop) act_ok = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int cycles, slots, big3;
        bit dropped, act_ok, seen_done;
        repeat (3) @(negedge clk);
        check(!bo_done && !frame_drop && !bo_active, "R1 reset outputs", {bo_done, frame_drop, bo_active}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bo_done && !frame_drop && !bo_active, "R1 after release", {bo_done, frame_drop, bo_active}, 0);

        big3 = 0;
        for (int v = 0; v < 8; v++) begin
            mode = VECS[v].md; buf_full = VECS[v].full; no_drop = VECS[v].nd;
            pulse(tx_start);
            for (int k = 1; k <= int'(VECS[v].ncoll); k++) begin
                collide(cycles, dropped, act_ok);
                if (k == int'(VECS[v].ncoll) && VECS[v].expdrop) begin
                    check(dropped && cycles == 1, "R7 drop at 16th", cycles, 1);
                end else begin
                    slots = (cycles - 1) / SB;
                    check(!dropped, "R8 no early drop", int'(dropped), 0);
                    check((cycles - 1) % SB == 0, "R2 whole slots", cycles - 1, slots * SB);
                    check(slots <= exp_max(VECS[v].md, VECS[v].full, k),
                          (VECS[v].md == 2'b01) ? "R4 capped window" :
                          (VECS[v].md == 2'b10) ? "R5 buffer window" :
                          (VECS[v].md == 2'b11) ? "R6 zero delay" : "R3 standard window",
                          slots, exp_max(VECS[v].md, VECS[v].full, k));
                    check(act_ok, "R10 active during wait", int'(act_ok), 1);
                    if (VECS[v].md == 2'b00 && slots > 3) big3++;
                end
            end
        end
        check(big3 > 0, "R3 window grows with attempts", big3, 1);

        // R2: no progress without bit_tick
        mode = 2'b00; no_drop = 1'b1; buf_full = 1'b0;
        pulse(tx_start);
        for (int t = 0; t < 12; t++) begin
            @(negedge clk); collision = 1'b1;
            @(negedge clk); collision = 1'b0;
            if (bo_active) break;
            while (!bo_done) @(negedge clk);
            @(negedge clk);
        end
        bit_tick = 1'b0;
        seen_done = 1'b0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (bo_done || !bo_active) seen_done = 1'b1;
        end
        check(!seen_done, "R2 stall without tick", int'(seen_done), 0);
        bit_tick = 1'b1;
        for (int t = 0; t < 6000 && !bo_done; t++) @(negedge clk);
        check(bo_done, "R2 resumes with tick", int'(bo_done), 1);
        @(negedge clk);
        check(!bo_done, "R2 done one cycle", int'(bo_done), 0);

        // R9: frame_done and tx_start clear the count
        mode = 2'b11; no_drop = 1'b0;
        pulse(tx_start);
        for (int k = 0; k < 15; k++) collide(cycles, dropped, act_ok);
        pulse(frame_done);
        for (int k = 0; k < 15; k++) begin
            collide(cycles, dropped, act_ok);
            check(!dropped && cycles == 1, "R9 frame_done clears count", int'(dropped), 0);
        end
        collide(cycles, dropped, act_ok);
        check(dropped, "R7 drop after 16 since clear", int'(dropped), 1);
        collide(cycles, dropped, act_ok);
        check(!dropped && cycles == 1, "R7 drop clears count", int'(dropped), 0);
        pulse(tx_start);
        for (int k = 0; k < 15; k++) collide(cycles, dropped, act_ok);
        pulse(tx_start);
        collide(cycles, dropped, act_ok);
        check(!dropped, "R9 tx_start clears count", int'(dropped), 0);

        // R1: reset mid-backoff
        mode = 2'b00;
        @(negedge clk); collision = 1'b1;
        @(negedge clk); collision = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(!bo_done && !frame_drop && !bo_active, "R1 reset clears wait", {bo_done, frame_drop, bo_active}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule